// File: doc/BRIEF.md
# Segmentable Four-Operand Carry-Save Compressor Row

This block reduces four equal-width operands, which usually hold two numbers in sum/carry redundant form, to a single redundant pair: a sum vector and a carry vector. It is a row of bit-level 4:2 compressors. Each bit passes one horizontal carry to its upper neighbour. That horizontal carry is computed from the cell's own first three operand bits only, so no signal ripples along the row. The row's delay is two full-adder levels whatever its width.

The row is built from `NSEG` segments of `SEG_W` bits each (default three segments of 9 bits). A cut input holds one bit per internal segment boundary. A set cut bit stops the horizontal carry at that boundary and clears the weighted carry of the bit just below it. Several packed narrow results can then be compressed side by side in one row without disturbing each other. With no cut bit set, the row acts as one compressor over its full width. Both outputs are registered. A final carry-propagate adder, shifters and accumulators belong to the surrounding datapath.

Top module: `seg_compress_row`

## Requirements
- R1: `sum_q` and `carry_q` change only at a rising edge of `clk`. After an edge with `rst` low they reflect the operands and `cut` that were present at that edge.
- R2: With `rst` high at a rising edge, both `sum_q` and `carry_q` become all zeros after that edge, whatever the operands.
- R3: With `cut` all zeros, `sum_q + 2*carry_q` equals `op_a + op_b + op_c + op_d` modulo 2^(NSEG*SEG_W). Bit i of `carry_q` has weight 2^(i+1).
- R4: Bit k of `cut` set places a boundary between bit (k+1)*SEG_W-1 and bit (k+1)*SEG_W. For every span of bits between neighbouring active boundaries (or the row ends), the span's slice of `sum_q`, plus twice the span's slice of `carry_q`, equals the sum of the span's slices of the four operands, modulo 2 to the span width.
- R5: The `carry_q` bit at the top of every span is 0. This includes bit NSEG*SEG_W-1, which is always 0.
- R6: The `sum_q` and `carry_q` bits of a span do not depend on operand bits outside that span.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | NSEG*SEG_W | First operand |
| op_b | input | NSEG*SEG_W | Second operand |
| op_c | input | NSEG*SEG_W | Third operand |
| op_d | input | NSEG*SEG_W | Fourth operand |
| cut | input | NSEG-1 | One bit per internal segment boundary; 1 isolates the spans on either side |
| sum_q | output | NSEG*SEG_W | Registered sum vector, bit i of weight 2^i |
| carry_q | output | NSEG*SEG_W | Registered carry vector, bit i of weight 2^(i+1) |

## Verification
The assertions check on every cycle that reset clears the outputs, that the top carry bit of the row and of every cut segment stays zero, and that the arithmetic identity holds for the full width when nothing is cut. They also check that it holds for the lowest segment under any cut pattern. The bench covers what the assertions do not express: the identity for every span under each of the four cut patterns, across sweeps of pseudo-random and corner operands. It also shows that a span's outputs stay fixed while the operands outside that span change, and that outputs do not move between clock edges.

// File: rtl/segcmp_pkg.sv
package segcmp_pkg;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  function automatic logic xor3(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

endpackage

// File: rtl/cmp42_hgen.sv
// Horizontal carry of one 4:2 bit: depends only on three operand bits.
module cmp42_hgen
  import segcmp_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic c,
  output logic h
);
  assign h = maj3(a, b, c);
endmodule

// File: rtl/cmp42_cell.sv
// Sum and weighted carry of one 4:2 bit, with a kill on the weighted carry.
module cmp42_cell
  import segcmp_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  input  logic ci,
  input  logic kill_w,
  output logic s,
  output logic cw
);
  logic s1;
  assign s1 = xor3(a, b, c);
  assign s  = xor3(s1, d, ci);
  assign cw = maj3(s1, d, ci) & ~kill_w;
endmodule

// File: rtl/cmp42_row.sv
// Combinational row of 4:2 bits with cuttable segment boundaries.
module cmp42_row #(
  parameter int SEG_W = 9,
  parameter int NSEG  = 3
) (
  input  logic [NSEG*SEG_W-1:0] op_a,
  input  logic [NSEG*SEG_W-1:0] op_b,
  input  logic [NSEG*SEG_W-1:0] op_c,
  input  logic [NSEG*SEG_W-1:0] op_d,
  input  logic [NSEG-2:0]       cut,
  output logic [NSEG*SEG_W-1:0] sum,
  output logic [NSEG*SEG_W-1:0] carry
);
  localparam int W = NSEG * SEG_W;

  logic [W-2:0] hx;
  logic [W-1:0] cin;
  logic [W-1:0] kill;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < W - 1) begin : g_h
      cmp42_hgen u_h (
        .a(op_a[i]), .b(op_b[i]), .c(op_c[i]), .h(hx[i])
      );
    end

    if (i == 0) begin : g_ci0
      assign cin[i] = 1'b0;
    end else if ((i % SEG_W) == 0) begin : g_cib
      assign cin[i] = hx[i-1] & ~cut[(i / SEG_W) - 1];
    end else begin : g_cin
      assign cin[i] = hx[i-1];
    end

    if (i == W - 1) begin : g_ktop
      assign kill[i] = 1'b1;
    end else if ((i % SEG_W) == SEG_W - 1) begin : g_kseg
      assign kill[i] = cut[i / SEG_W];
    end else begin : g_knone
      assign kill[i] = 1'b0;
    end

    cmp42_cell u_cell (
      .a(op_a[i]), .b(op_b[i]), .c(op_c[i]), .d(op_d[i]),
      .ci(cin[i]), .kill_w(kill[i]),
      .s(sum[i]), .cw(carry[i])
    );
  end
endmodule

// File: rtl/seg_compress_row.sv
module seg_compress_row #(
  parameter int SEG_W = 9,
  parameter int NSEG  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSEG*SEG_W-1:0] op_a,
  input  logic [NSEG*SEG_W-1:0] op_b,
  input  logic [NSEG*SEG_W-1:0] op_c,
  input  logic [NSEG*SEG_W-1:0] op_d,
  input  logic [NSEG-2:0]       cut,
  output logic [NSEG*SEG_W-1:0] sum_q,
  output logic [NSEG*SEG_W-1:0] carry_q
);
  localparam int W = NSEG * SEG_W;

  logic [W-1:0] sum_n;
  logic [W-1:0] carry_n;

  cmp42_row #(.SEG_W(SEG_W), .NSEG(NSEG)) u_row (
    .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
    .cut(cut), .sum(sum_n), .carry(carry_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      carry_q <= '0;
    end else begin
      sum_q   <= sum_n;
      carry_q <= carry_n;
    end
  end
endmodule

// File: rtl/seg_compress_row_chk.sv
module seg_compress_row_chk #(
  parameter int SEG_W = 9,
  parameter int NSEG  = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NSEG*SEG_W-1:0] op_a,
  input logic [NSEG*SEG_W-1:0] op_b,
  input logic [NSEG*SEG_W-1:0] op_c,
  input logic [NSEG*SEG_W-1:0] op_d,
  input logic [NSEG-2:0]       cut,
  input logic [NSEG*SEG_W-1:0] sum_q,
  input logic [NSEG*SEG_W-1:0] carry_q
);
  localparam int W = NSEG * SEG_W;

  logic [W-1:0] in_tot;
  logic [W-1:0] out_tot;
  assign in_tot  = op_a + op_b + op_c + op_d;
  assign out_tot = sum_q + {carry_q[W-2:0], 1'b0};

  // R2
  a_r2_reset_clear: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && carry_q == '0));

  // R5
  a_r5_row_top_zero: assert property (@(posedge clk) disable iff (rst)
    carry_q[W-1] == 1'b0);

  for (genvar k = 0; k < NSEG - 1; k++) begin : g_cut
    // R5
    a_r5_cut_top_zero: assert property (@(posedge clk) disable iff (rst)
      cut[k] |=> carry_q[(k+1)*SEG_W-1] == 1'b0);
  end

  // R3, R1
  a_r3_full_width: assert property (@(posedge clk) disable iff (rst)
    (cut == '0) |=> out_tot == $past(in_tot));

  // R4
  a_r4_low_span: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_tot[SEG_W-1:0] == $past(in_tot[SEG_W-1:0]));
endmodule

bind seg_compress_row seg_compress_row_chk #(.SEG_W(SEG_W), .NSEG(NSEG)) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
  .cut(cut), .sum_q(sum_q), .carry_q(carry_q)
);

// File: tb/seg_compress_row_test.sv
module seg_compress_row_test;
  localparam int SEG_W = 9;
  localparam int NSEG  = 3;
  localparam int W     = NSEG * SEG_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a = '0, b = '0, c = '0, d = '0;
  logic [NSEG-2:0] cut = '0;
  logic [W-1:0] sq, cq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [63:0] rs = 64'h9E3779B97F4A7C15;

  always #4 clk = ~clk;

  seg_compress_row #(.SEG_W(SEG_W), .NSEG(NSEG)) uut (
    .clk(clk), .rst(rst), .op_a(a), .op_b(b), .op_c(c), .op_d(d),
    .cut(cut), .sum_q(sq), .carry_q(cq)
  );

  function automatic logic [W-1:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    return rs[W-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input longint unsigned got,
                     input longint unsigned exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] ia, input logic [W-1:0] ib,
                       input logic [W-1:0] ic, input logic [W-1:0] id,
                       input logic [NSEG-2:0] m);
    @(negedge clk);
    a = ia; b = ib; c = ic; d = id; cut = m;
    @(negedge clk);
  endtask

  // R3 when nothing is cut, R4 otherwise; R5 on every span top.
  task automatic check_spans();
    int lo = 0;
    for (int k = 0; k < NSEG; k++) begin
      int hi = (k + 1) * SEG_W - 1;
      if (k == NSEG - 1 || cut[k]) begin
        int len = hi - lo + 1;
        longint unsigned msk = (64'd1 << len) - 1;
        longint unsigned ex, gt;
        ex = (((64'(a) >> lo) & msk) + ((64'(b) >> lo) & msk) +
              ((64'(c) >> lo) & msk) + ((64'(d) >> lo) & msk)) & msk;
        gt = (((64'(sq) >> lo) & msk) + 2 * ((64'(cq) >> lo) & msk)) & msk;
        chk(gt == ex, (cut == '0) ? "R3" : "R4", gt, ex);
        chk(cq[hi] == 1'b0, "R5", 64'(cq[hi]), 0);
        lo = hi + 1;
      end
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog got=hung exp=done");
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] ref_s, ref_c, keep;

    // R2: reset clears outputs despite nonzero operands
    rst = 1'b1;
    apply({W{1'b1}}, {W{1'b1}}, 27'h5A5A5A5, 27'h1234567, 2'b00);
    chk(sq == '0 && cq == '0, "R2", 64'(sq) | 64'(cq), 0);

    // R1: first edge after reset release reflects operands
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_spans();

    // R1: no change between edges
    ref_s = sq; ref_c = cq;
    a = rnd(); b = rnd(); c = rnd(); d = rnd();
    #1;
    chk(sq == ref_s && cq == ref_c, "R1", 64'(sq), 64'(ref_s));
    @(negedge clk);
    check_spans();

    // R3/R4/R5 sweep over every cut pattern
    for (int m = 0; m < (1 << (NSEG - 1)); m++) begin
      apply('0, '0, '0, '0, m[NSEG-2:0]);
      check_spans();
      apply({W{1'b1}}, {W{1'b1}}, {W{1'b1}}, {W{1'b1}}, m[NSEG-2:0]);
      check_spans();
      for (int j = 0; j < W; j++) begin
        apply(W'(1) << j, W'(1) << j, W'(1) << j, W'(1) << j, m[NSEG-2:0]);
        check_spans();
      end
      for (int t = 0; t < 400; t++) begin
        apply(rnd(), rnd(), rnd(), rnd(), m[NSEG-2:0]);
        check_spans();
      end
    end

    // R4: with only the lowest boundary cut, saturated low segment leaks nothing upward
    apply(27'h1FF, 27'h1FF, 27'h1FF, 27'h1FF, 2'b01);
    chk(sq[W-1:SEG_W] == '0 && cq[W-1:SEG_W-1] == '0, "R4",
        64'(sq[W-1:SEG_W]), 0);
    check_spans();

    // R6: middle span isolated with both cuts; vary outer segments
    begin
      logic [W-1:0] ba, bb, bc, bd;
      ba = rnd(); bb = rnd(); bc = rnd(); bd = rnd();
      keep = {{SEG_W{1'b0}}, {SEG_W{1'b1}}, {SEG_W{1'b0}}};
      apply(ba, bb, bc, bd, 2'b11);
      ref_s = sq & keep; ref_c = cq & keep;
      for (int t = 0; t < 40; t++) begin
        apply((ba & keep) | (rnd() & ~keep), (bb & keep) | (rnd() & ~keep),
              (bc & keep) | (rnd() & ~keep), (bd & keep) | (rnd() & ~keep), 2'b11);
        chk((sq & keep) == ref_s && (cq & keep) == ref_c, "R6",
            64'(sq & keep), 64'(ref_s));
      end
      // R6: upper span (bits 9..26) isolated from segment 0 with lowest cut only
      keep = {{(W-SEG_W){1'b1}}, {SEG_W{1'b0}}};
      apply(ba, bb, bc, bd, 2'b01);
      ref_s = sq & keep; ref_c = cq & keep;
      for (int t = 0; t < 40; t++) begin
        apply((ba & keep) | (rnd() & ~keep), (bb & keep) | (rnd() & ~keep),
              (bc & keep) | (rnd() & ~keep), (bd & keep) | (rnd() & ~keep), 2'b01);
        chk((sq & keep) == ref_s && (cq & keep) == ref_c, "R6",
            64'(sq & keep), 64'(ref_s));
      end
    end

    // R2: reset in mid-run clears again
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(sq == '0 && cq == '0, "R2", 64'(sq) | 64'(cq), 0);

    done = 1'b1;
    finish_run();
  end
endmodule